// File: doc/BRIEF.md
# Standby Pin Buffer Controller

This block sits beside one general-purpose port and decides, pin by pin, whether the pad's output driver and input receiver stay powered while the chip sleeps. Software loads an 8-bit drive mask ahead of time, one bit per pin. While the chip runs, the mask has no effect: each output driver follows that pin's direction bit, and each receiver is enabled whenever the driver is not.

When the halt strobe arrives, the block freezes a private copy of two things: the direction bits in force at that moment and the current drive mask. For as long as the standby level stays high, every pin's driver and receiver are set from its frozen direction bit and frozen mask bit. The same rule applies to the light idle, deep idle and stop modes, because the block sees only one standby level. Any writes software makes to the mask during standby can be read back, but they take effect only at the next halt.

Top module: `standby_buf_ctrl`

## Requirements
- R1: After reset the drive mask reads all ones (8'hFF). Before the first halt strobe, the frozen copy holds direction 0 and mask 1 for every pin.
- R2: A write with `wr_en_i` high replaces the mask, and the new value appears on `rd_data_o` one clock later.
- R3: With `stby_active_i` low, `obuf_en_o` equals the live `dir_oe_i`, and `ibuf_en_o` is its bitwise inverse.
- R4: In standby, a pin whose frozen direction is 0 and frozen mask bit is 0 has both its driver bit and its receiver bit at 0.
- R5: In standby, a pin whose frozen direction is 0 and frozen mask bit is 1 has its driver bit at 0 and its receiver bit at 1.
- R6: In standby, a pin whose frozen direction is 1 and frozen mask bit is 0 has both its driver bit and its receiver bit at 0.
- R7: In standby, a pin whose frozen direction is 1 and frozen mask bit is 1 has its driver bit at 1 and its receiver bit at 0.
- R8: The frozen copy is taken at the clock edge where `stby_enter_i` is high. Changes on `dir_oe_i` during standby do not change the outputs.
- R9: A mask write during standby changes `rd_data_o` but not the standby outputs. The written value governs the next standby period entered after the write.
- R10: No pin ever has its driver bit and its receiver bit high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Mask write strobe |
| wr_data_i | input | NUM_PINS | Mask write value |
| rd_data_o | output | NUM_PINS | Mask readback |
| stby_enter_i | input | 1 | Halt strobe that freezes direction and mask |
| stby_active_i | input | 1 | High for the whole standby period |
| dir_oe_i | input | NUM_PINS | Live output enables from the direction register |
| obuf_en_o | output | NUM_PINS | Per-pin output driver enable |
| ibuf_en_o | output | NUM_PINS | Per-pin input receiver enable |

## Verification
The bench uses the default NUM_PINS of 8. That width is large enough to place all four direction/mask combinations of the standby table in one byte, so a single halt checks every row of the table side by side on different pins. Eight pins also allow a direction pattern and its complement to be swapped during standby, so every pin shows that the frozen copy ignores the live input. A final halt with a fresh mask shows that a write made while asleep takes effect only on the next entry.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_STBY = 1'b1
    } buf_mode_e;

    typedef struct packed {
        logic obuf;
        logic ibuf;
    } pin_buf_t;

    // Standby table: driver only when output was enabled and mask bit set;
    // receiver only when output was disabled and mask bit set.
    function automatic pin_buf_t stby_lookup(input logic oe, input logic drv);
        pin_buf_t r;
        unique case ({oe, drv})
            2'b00:   r = '{obuf: 1'b0, ibuf: 1'b0};
            2'b01:   r = '{obuf: 1'b0, ibuf: 1'b1};
            2'b10:   r = '{obuf: 1'b0, ibuf: 1'b0};
            default: r = '{obuf: 1'b1, ibuf: 1'b0};
        endcase
        return r;
    endfunction

    function automatic pin_buf_t run_lookup(input logic oe);
        pin_buf_t r;
        r.obuf = oe;
        r.ibuf = ~oe;
        return r;
    endfunction

endpackage

// File: rtl/sbc_drive_reg.sv
module sbc_drive_reg #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [NUM_PINS-1:0] wr_data_i,
    output logic [NUM_PINS-1:0] mask_o
);

    localparam logic [NUM_PINS-1:0] MaskReset = {NUM_PINS{1'b1}};

    typedef struct packed {
        logic [NUM_PINS-1:0] mask;
    } reg_state_t;

    reg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            state_d.mask = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.mask <= MaskReset;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_o = state_q.mask;

endmodule

// File: rtl/sbc_shadow.sv
module sbc_shadow #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                capture_i,
    input  logic [NUM_PINS-1:0] oe_i,
    input  logic [NUM_PINS-1:0] mask_i,
    output logic [NUM_PINS-1:0] oe_frz_o,
    output logic [NUM_PINS-1:0] mask_frz_o
);

    localparam logic [NUM_PINS-1:0] OeReset   = '0;
    localparam logic [NUM_PINS-1:0] MaskReset = {NUM_PINS{1'b1}};

    typedef struct packed {
        logic [NUM_PINS-1:0] oe;
        logic [NUM_PINS-1:0] mask;
    } shadow_t;

    shadow_t shadow_d, shadow_q;

    always_comb begin
        shadow_d = shadow_q;
        if (capture_i) begin
            shadow_d.oe   = oe_i;
            shadow_d.mask = mask_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shadow_q.oe   <= OeReset;
            shadow_q.mask <= MaskReset;
        end else begin
            shadow_q <= shadow_d;
        end
    end

    assign oe_frz_o   = shadow_q.oe;
    assign mask_frz_o = shadow_q.mask;

endmodule

// File: rtl/sbc_buf_decode.sv
module sbc_buf_decode
    import sbc_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  buf_mode_e           mode_i,
    input  logic [NUM_PINS-1:0] oe_live_i,
    input  logic [NUM_PINS-1:0] oe_frz_i,
    input  logic [NUM_PINS-1:0] mask_frz_i,
    output logic [NUM_PINS-1:0] obuf_en_o,
    output logic [NUM_PINS-1:0] ibuf_en_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_buf_t sel;
        always_comb begin
            if (mode_i == MODE_STBY) begin
                sel = stby_lookup(oe_frz_i[p], mask_frz_i[p]);
            end else begin
                sel = run_lookup(oe_live_i[p]);
            end
        end
        assign obuf_en_o[p] = sel.obuf;
        assign ibuf_en_o[p] = sel.ibuf;
    end

endmodule

// File: rtl/standby_buf_ctrl.sv
module standby_buf_ctrl
    import sbc_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [NUM_PINS-1:0] wr_data_i,
    output logic [NUM_PINS-1:0] rd_data_o,
    input  logic                stby_enter_i,
    input  logic                stby_active_i,
    input  logic [NUM_PINS-1:0] dir_oe_i,
    output logic [NUM_PINS-1:0] obuf_en_o,
    output logic [NUM_PINS-1:0] ibuf_en_o
);

    logic [NUM_PINS-1:0] mask;
    logic [NUM_PINS-1:0] oe_frz;
    logic [NUM_PINS-1:0] mask_frz;
    buf_mode_e           mode;

    assign mode = stby_active_i ? MODE_STBY : MODE_RUN;

    sbc_drive_reg #(.NUM_PINS(NUM_PINS)) u_reg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .mask_o    (mask)
    );

    sbc_shadow #(.NUM_PINS(NUM_PINS)) u_shadow (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .capture_i  (stby_enter_i),
        .oe_i       (dir_oe_i),
        .mask_i     (mask),
        .oe_frz_o   (oe_frz),
        .mask_frz_o (mask_frz)
    );

    sbc_buf_decode #(.NUM_PINS(NUM_PINS)) u_dec (
        .mode_i     (mode),
        .oe_live_i  (dir_oe_i),
        .oe_frz_i   (oe_frz),
        .mask_frz_i (mask_frz),
        .obuf_en_o  (obuf_en_o),
        .ibuf_en_o  (ibuf_en_o)
    );

    assign rd_data_o = mask;

endmodule

// File: rtl/standby_buf_ctrl_checker.sv
module standby_buf_ctrl_checker #(
    parameter int NUM_PINS = 8
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                wr_en_i,
    input logic [NUM_PINS-1:0] wr_data_i,
    input logic [NUM_PINS-1:0] rd_data_o,
    input logic                stby_enter_i,
    input logic                stby_active_i,
    input logic [NUM_PINS-1:0] dir_oe_i,
    input logic [NUM_PINS-1:0] obuf_en_o,
    input logic [NUM_PINS-1:0] ibuf_en_o
);

    AST_RESET_MASK_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rst_ni) |-> (rd_data_o == {NUM_PINS{1'b1}})); // R1

    AST_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (rd_data_o == $past(wr_data_i))); // R2

    AST_RUN_DIR_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stby_active_i |-> ((obuf_en_o == dir_oe_i) && (ibuf_en_o == ~dir_oe_i))); // R3

    AST_STBY_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stby_active_i && $past(stby_active_i) && !$past(stby_enter_i))
        |-> ($stable(obuf_en_o) && $stable(ibuf_en_o))); // R8

    AST_STBY_WRITE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stby_active_i && wr_en_i && !stby_enter_i) |=>
        (!stby_active_i || ($stable(obuf_en_o) && $stable(ibuf_en_o)))); // R9

    AST_NO_DUAL_BUFFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((obuf_en_o & ibuf_en_o) == '0)); // R10

endmodule

bind standby_buf_ctrl standby_buf_ctrl_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .rd_data_o     (rd_data_o),
    .stby_enter_i  (stby_enter_i),
    .stby_active_i (stby_active_i),
    .dir_oe_i      (dir_oe_i),
    .obuf_en_o     (obuf_en_o),
    .ibuf_en_o     (ibuf_en_o)
);

// File: tb/standby_buf_ctrl_tb.sv
`timescale 1ns/1ps
module standby_buf_ctrl_tb;

    localparam int N = 8;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         wr_en_i = 1'b0;
    logic [N-1:0] wr_data_i = '0;
    logic [N-1:0] rd_data_o;
    logic         stby_enter_i = 1'b0;
    logic         stby_active_i = 1'b0;
    logic [N-1:0] dir_oe_i = '0;
    logic [N-1:0] obuf_en_o;
    logic [N-1:0] ibuf_en_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #10 clk_i = ~clk_i;

    standby_buf_ctrl #(.NUM_PINS(N)) u_dut (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .rd_data_o     (rd_data_o),
        .stby_enter_i  (stby_enter_i),
        .stby_active_i (stby_active_i),
        .dir_oe_i      (dir_oe_i),
        .obuf_en_o     (obuf_en_o),
        .ibuf_en_o     (ibuf_en_o)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Expected standby outputs from the requirement table, pin by pin
    function automatic logic [N-1:0] exp_obuf(input logic [N-1:0] oe, input logic [N-1:0] m);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = (oe[i] == 1'b1 && m[i] == 1'b1);
        return r;
    endfunction

    function automatic logic [N-1:0] exp_ibuf(input logic [N-1:0] oe, input logic [N-1:0] m);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = (oe[i] == 1'b0 && m[i] == 1'b1);
        return r;
    endfunction

    task automatic write_mask(input logic [N-1:0] v);
        @(negedge clk_i);
        wr_en_i   = 1'b1;
        wr_data_i = v;
        @(negedge clk_i);
        wr_en_i   = 1'b0;
    endtask

    task automatic enter_standby();
        @(negedge clk_i);
        stby_enter_i = 1'b1;
        @(negedge clk_i);
        stby_enter_i  = 1'b0;
        stby_active_i = 1'b1;
        #1;
    endtask

    task automatic leave_standby();
        @(negedge clk_i);
        stby_active_i = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        dir_oe_i = 8'h00;
        @(negedge clk_i);
        check("R1 mask reset", rd_data_o, 8'hFF);
        check("R3 run obuf", obuf_en_o, 8'h00);
        check("R3 run ibuf", ibuf_en_o, 8'hFF);
        // standby without any prior halt strobe: frozen dir 0, mask 1
        dir_oe_i = 8'hF0;
        stby_active_i = 1'b1;
        #1;
        check("R1 frozen default obuf", obuf_en_o, 8'h00);
        check("R1 frozen default ibuf", ibuf_en_o, 8'hFF);
        leave_standby();
    endtask

    task automatic t_write();
        write_mask(8'h3C);
        check("R2 readback", rd_data_o, 8'h3C);
        write_mask(8'hAA);
        check("R2 readback 2", rd_data_o, 8'hAA);
    endtask

    task automatic t_run();
        dir_oe_i = 8'h5A;
        #1;
        check("R3 obuf", obuf_en_o, 8'h5A);
        check("R3 ibuf", ibuf_en_o, 8'hA5);
        dir_oe_i = 8'hC3;
        #1;
        check("R3 obuf 2", obuf_en_o, 8'hC3);
        check("R3 ibuf 2", ibuf_en_o, 8'h3C);
    endtask

    // oe = 1100_1100, mask = 1010_1010 puts every table row on two pins
    task automatic t_table();
        logic [N-1:0] oe = 8'hCC;
        logic [N-1:0] m  = 8'hAA;
        write_mask(m);
        dir_oe_i = oe;
        enter_standby();
        // R4 pins 0,4 (oe0 m0); R5 pins 1,5 (oe0 m1); R6 pins 2,6; R7 pins 3,7
        check("R4 obuf bits", obuf_en_o & 8'h11, 8'h00);
        check("R4 ibuf bits", ibuf_en_o & 8'h11, 8'h00);
        check("R5 obuf bits", obuf_en_o & 8'h22, 8'h00);
        check("R5 ibuf bits", ibuf_en_o & 8'h22, 8'h22);
        check("R6 obuf bits", obuf_en_o & 8'h44, 8'h00);
        check("R6 ibuf bits", ibuf_en_o & 8'h44, 8'h00);
        check("R7 obuf bits", obuf_en_o & 8'h88, 8'h88);
        check("R7 ibuf bits", ibuf_en_o & 8'h88, 8'h00);
        check("R10 no dual", obuf_en_o & ibuf_en_o, 8'h00);
        // R8: live direction changes are ignored while asleep
        dir_oe_i = ~oe;
        repeat (3) @(negedge clk_i);
        check("R8 obuf frozen", obuf_en_o, exp_obuf(oe, m));
        check("R8 ibuf frozen", ibuf_en_o, exp_ibuf(oe, m));
        // R9: write during standby
        write_mask(8'h0F);
        check("R9 readback", rd_data_o, 8'h0F);
        check("R9 obuf unchanged", obuf_en_o, exp_obuf(oe, m));
        check("R9 ibuf unchanged", ibuf_en_o, exp_ibuf(oe, m));
        leave_standby();
        check("R3 after exit obuf", obuf_en_o, ~oe);
        check("R3 after exit ibuf", ibuf_en_o, oe);
    endtask

    task automatic t_reentry();
        logic [N-1:0] oe = 8'h33;
        dir_oe_i = oe;
        enter_standby();
        check("R9 new mask obuf", obuf_en_o, exp_obuf(oe, 8'h0F));
        check("R9 new mask ibuf", ibuf_en_o, exp_ibuf(oe, 8'h0F));
        check("R10 no dual 2", obuf_en_o & ibuf_en_o, 8'h00);
        leave_standby();
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_write();
        t_run();
        t_table();
        t_reentry();
        repeat (2) @(negedge clk_i);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule